// File: doc/BRIEF.md
# Transmit Output Mode Sequencer

This block drives the control lines around the transmit analog path of a narrowband modem. It has two inputs: a modulator-enable input and a filter-power input. From them it produces three controls. The first selects what feeds the transmit low-pass filter: the digital modulator or the voice input. The second selects what reaches the analog output pin: signal ground, the transmit filter, or the receive band-pass filter. The third powers the transmit filter down. The switches and the filters themselves sit outside the block.

A switched-capacitor filter that has just been powered up produces garbage while it settles. Each time filter power goes from low to high, the block therefore keeps the output tied to signal ground for a blanking window of about 2 ms, and only then hands the output to the filter. The window is counted in master-clock cycles. The terminal count comes from the clock-select input, so the hold is the same at either master frequency. If power drops during the window, blanking stops at once. Changing the enable input while the filter is powered never reopens the window.

Top module: `tx_route_seq`

## Requirements
- R1: With enable 1 and filter power 1, after blanking, `out_sel` = 1 (transmit filter), `filt_pd` = 0 and `filt_in_sel` = 1 (modulator).
- R2: With enable 0 and filter power 1, after blanking, `out_sel` = 1 (transmit filter), `filt_pd` = 0 and `filt_in_sel` = 0 (voice input).
- R3: With enable 1 and filter power 0, `filt_pd` = 1 and `out_sel` = 2 (receive band-pass filter).
- R4: With enable 0 and filter power 0, `filt_pd` = 1 and `out_sel` = 0 (signal ground).
- R5: Filter power goes high, and the first clock edge that samples it high is edge k. From the moment power goes high up to edge k+TC−1 inclusive, `out_sel` = 0 and `filt_pd` = 0. After edge k+TC, `out_sel` = 1. TC = CLK_LO_HZ·HOLD_US/10^6 when `clk_sel` = 0 at edge k, and CLK_HI_HZ·HOLD_US/10^6 when `clk_sel` = 1 at edge k.
- R6: `filt_in_sel` equals the enable input at all times, in every power state, with no clock delay.
- R7: When filter power drops during blanking, `filt_pd` = 1 in the same cycle and the routing follows R3/R4. The next rising edge of filter power starts a full new window of TC cycles.
- R8: Changing the enable input while the filter is powered and routed to the output leaves `out_sel` = 1 and does not restart blanking.
- R9: While reset is asserted, `out_sel` = 0 and `filt_pd` = 1. Filter power that is already high when reset is released counts as a fresh rising edge and gets a full blanking window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_sel | input | 1 | Master frequency select: 0 low, 1 high |
| mod_en | input | 1 | Modulator enable |
| filt_pwr | input | 1 | Transmit filter power request |
| filt_in_sel | output | 1 | Filter input mux: 1 modulator, 0 voice |
| out_sel | output | 2 | Output mux: 0 ground, 1 transmit filter, 2 receive band-pass |
| filt_pd | output | 1 | Transmit filter power-down, active high |

## Verification
The bench measures the blanking window to the exact edge at both clock selections. An off-by-one counter would show the filter one cycle early or one cycle late. The bench drops power in the middle of a window and then raises it again. A design that failed to clear its counter would shorten the second window, and one that failed to abort would keep the output grounded while the filter is powered down. The bench also toggles enable while the filter is routed to the output, which catches a design that treats any input change as a restart. Finally, the bench holds power high across reset release, which exposes a design that misses the implied rising edge and routes the filter immediately.

// File: rtl/tx_route_pkg.sv
package tx_route_pkg;
   typedef enum logic [1:0] {
      RT_GND   = 2'd0,
      RT_TXF   = 2'd1,
      RT_RXBPF = 2'd2
   } route_e;
endpackage

// File: rtl/txr_sync.sv
module txr_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] stg [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
         end else begin
            stg[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
         end
      end
      assign q = stg[STAGES-1];
   end
endmodule

// File: rtl/txr_blank_timer.sv
module txr_blank_timer #(
   parameter int unsigned TC_LO = 7372,
   parameter int unsigned TC_HI = 14745
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_sel,
   input  logic pwr,
   output logic hold
);
   localparam int unsigned TC_MAX = (TC_HI > TC_LO) ? TC_HI : TC_LO;
   localparam int unsigned CW     = $clog2(TC_MAX + 1);

   logic          pwr_q;
   logic          blank_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] tc_q;
   logic          rise;

   assign rise = pwr & ~pwr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_q   <= 1'b0;
         blank_q <= 1'b0;
         cnt_q   <= '0;
         tc_q    <= CW'(TC_LO);
      end else begin
         pwr_q <= pwr;
         if (rise) begin
            blank_q <= 1'b1;
            cnt_q   <= '0;
            tc_q    <= clk_sel ? CW'(TC_HI) : CW'(TC_LO);
         end else if (!pwr) begin
            blank_q <= 1'b0;
            cnt_q   <= '0;
         end else if (blank_q) begin
            if (cnt_q == tc_q - 1'b1) begin
               blank_q <= 1'b0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign hold = rise | blank_q;
endmodule

// File: rtl/txr_route_dec.sv
module txr_route_dec
   import tx_route_pkg::*;
(
   input  logic       inhibit,
   input  logic       me,
   input  logic       pwr,
   input  logic       hold,
   output logic       in_sel,
   output logic [1:0] route,
   output logic       pd
);
   route_e r;

   always_comb begin
      pd = 1'b1;
      r  = RT_GND;
      if (inhibit) begin
         pd = 1'b1;
         r  = RT_GND;
      end else if (!pwr) begin
         pd = 1'b1;
         r  = me ? RT_RXBPF : RT_GND;
      end else begin
         pd = 1'b0;
         r  = hold ? RT_GND : RT_TXF;
      end
   end

   assign route  = r;
   assign in_sel = me;
endmodule

// File: rtl/tx_route_seq.sv
module tx_route_seq #(
   parameter int unsigned CLK_LO_HZ   = 3686400,
   parameter int unsigned CLK_HI_HZ   = 7372800,
   parameter int unsigned HOLD_US     = 2000,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clk_sel,
   input  logic       mod_en,
   input  logic       filt_pwr,
   output logic       filt_in_sel,
   output logic [1:0] out_sel,
   output logic       filt_pd
);
   localparam int unsigned TC_LO =
      int'((64'(CLK_LO_HZ) * 64'(HOLD_US)) / 64'd1000000);
   localparam int unsigned TC_HI =
      int'((64'(CLK_HI_HZ) * 64'(HOLD_US)) / 64'd1000000);

   if (HOLD_US == 0) begin : g_bad_hold
      $error("tx_route_seq: HOLD_US must be nonzero");
   end
   if (TC_LO < 2 || TC_HI < 2) begin : g_bad_tc
      $error("tx_route_seq: blanking count must be at least 2 cycles");
   end
   if (SYNC_STAGES > 3) begin : g_bad_sync
      $error("tx_route_seq: SYNC_STAGES above 3 not supported");
   end

   logic [1:0] in_s;
   logic       me_s;
   logic       pwr_s;
   logic       hold;

   txr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({mod_en, filt_pwr}),
      .q     (in_s)
   );
   assign me_s  = in_s[1];
   assign pwr_s = in_s[0];

   txr_blank_timer #(.TC_LO(TC_LO), .TC_HI(TC_HI)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clk_sel (clk_sel),
      .pwr     (pwr_s),
      .hold    (hold)
   );

   txr_route_dec u_dec (
      .inhibit (~rst_n),
      .me      (me_s),
      .pwr     (pwr_s),
      .hold    (hold),
      .in_sel  (filt_in_sel),
      .route   (out_sel),
      .pd      (filt_pd)
   );
endmodule

// File: rtl/txr_chk.sv
module txr_chk #(
   parameter int unsigned TC_LO = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       pwr_s,
   input logic       me_s,
   input logic [1:0] out_sel,
   input logic       filt_pd,
   input logic       filt_in_sel
);
   logic [31:0] on_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               on_cnt <= '0;
      else if (!pwr_s)          on_cnt <= '0;
      else if (on_cnt != '1)    on_cnt <= on_cnt + 32'd1;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_SG: assert (out_sel == 2'd0 && filt_pd); // R9
      end
   end

   AST_RISE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_s) |-> (out_sel == 2'd0 && !filt_pd)); // R5

   AST_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sel == 2'd1) |-> (on_cnt > TC_LO)); // R5

   AST_TX_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sel == 2'd1) |=> (!pwr_s || out_sel == 2'd1)); // R8

   AST_PD_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_s |-> (filt_pd && out_sel != 2'd1)); // R3

   AST_DROP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_s) |-> (filt_pd && out_sel == (me_s ? 2'd2 : 2'd0))); // R7

   AST_TX_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sel == 2'd1) |-> !filt_pd); // R1

   AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      out_sel != 2'd3); // R4

   AST_IN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(me_s) |-> (filt_in_sel == me_s)); // R6
endmodule

bind tx_route_seq txr_chk #(.TC_LO(TC_LO)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pwr_s       (pwr_s),
   .me_s        (me_s),
   .out_sel     (out_sel),
   .filt_pd     (filt_pd),
   .filt_in_sel (filt_in_sel)
);

// File: tb/tb_tx_route_seq.sv
module tb_tx_route_seq;
   localparam int unsigned LO_HZ = 10000;
   localparam int unsigned HI_HZ = 20000;
   localparam int unsigned HUS   = 2000;
   localparam int TCL = 20;   // LO_HZ*HUS/1e6
   localparam int TCH = 40;   // HI_HZ*HUS/1e6

   // {me, pwr, exp_out[1:0], exp_pd, exp_in}
   localparam logic [5:0] VEC [6] = '{
      6'b00_00_1_0,
      6'b10_10_1_1,
      6'b11_01_0_1,
      6'b01_01_0_0,
      6'b00_00_1_0,
      6'b11_01_0_1
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clk_sel = 1'b0;
   logic       mod_en = 1'b0;
   logic       filt_pwr = 1'b0;
   logic       filt_in_sel;
   logic [1:0] out_sel;
   logic       filt_pd;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   tx_route_seq #(.CLK_LO_HZ(LO_HZ), .CLK_HI_HZ(HI_HZ), .HOLD_US(HUS)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .clk_sel     (clk_sel),
      .mod_en      (mod_en),
      .filt_pwr    (filt_pwr),
      .filt_in_sel (filt_in_sel),
      .out_sel     (out_sel),
      .filt_pd     (filt_pd)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [1:0] eo,
                      input logic epd, input logic ein);
      #1;
      checks++;
      if (out_sel !== eo || filt_pd !== epd || filt_in_sel !== ein) begin
         failures++;
         $display("FAIL %s: out_sel=%0d filt_pd=%0b in_sel=%0b expected out_sel=%0d filt_pd=%0b in_sel=%0b",
                  tag, out_sel, filt_pd, filt_in_sel, eo, epd, ein);
      end
   endtask

   task automatic blank_window(input string tag, input int tc, input logic me);
      // power just rose before this call; output grounded, filter on
      chk(tag, 2'd0, 1'b0, me);
      tick(1);
      tick(tc - 1);
      chk(tag, 2'd0, 1'b0, me);
      tick(1);
      chk(tag, 2'd1, 1'b0, me);
   endtask

   initial begin
      #1_500_000;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      // R9 reset state
      @(negedge clk);
      chk("R9 in reset", 2'd0, 1'b1, 1'b0);
      tick(2);
      rst_n = 1'b1;
      tick(1);
      chk("R4 after reset", 2'd0, 1'b1, 1'b0);

      // table of steady routings (R1..R4)
      for (int i = 0; i < 6; i++) begin
         mod_en   = VEC[i][5];
         filt_pwr = VEC[i][4];
         tick(TCH + 10);
         case (VEC[i][5:4])
            2'b11:   chk("R1 table", VEC[i][3:2], VEC[i][1], VEC[i][0]);
            2'b01:   chk("R2 table", VEC[i][3:2], VEC[i][1], VEC[i][0]);
            2'b10:   chk("R3 table", VEC[i][3:2], VEC[i][1], VEC[i][0]);
            default: chk("R4 table", VEC[i][3:2], VEC[i][1], VEC[i][0]);
         endcase
      end

      // R8: enable toggles while routed to filter
      mod_en = 1'b0;
      chk("R8 toggle", 2'd1, 1'b0, 1'b0);
      tick(1);
      chk("R8 toggle", 2'd1, 1'b0, 1'b0);
      mod_en = 1'b1;
      tick(3);
      chk("R8 toggle back", 2'd1, 1'b0, 1'b1);

      // R6: input mux follows enable while powered down
      filt_pwr = 1'b0;
      tick(2);
      mod_en = 1'b0;
      chk("R6 pd", 2'd0, 1'b1, 1'b0);
      mod_en = 1'b1;
      chk("R6 pd", 2'd2, 1'b1, 1'b1);
      tick(2);

      // R5 exact window, low clock
      clk_sel  = 1'b0;
      filt_pwr = 1'b1;
      blank_window("R5 lo", TCL, 1'b1);

      // R5 exact window, high clock
      filt_pwr = 1'b0;
      tick(2);
      clk_sel  = 1'b1;
      mod_en   = 1'b0;
      filt_pwr = 1'b1;
      blank_window("R5 hi", TCH, 1'b0);

      // R7 abort mid-window and restart full
      filt_pwr = 1'b0;
      tick(2);
      clk_sel  = 1'b0;
      mod_en   = 1'b1;
      filt_pwr = 1'b1;
      tick(10);
      chk("R7 mid", 2'd0, 1'b0, 1'b1);
      filt_pwr = 1'b0;
      chk("R7 abort", 2'd2, 1'b1, 1'b1);
      tick(1);
      filt_pwr = 1'b1;
      blank_window("R7 restart", TCL, 1'b1);

      // R9 power held high across reset release
      mod_en = 1'b0;
      rst_n  = 1'b0;
      tick(1);
      chk("R9 reset pwr high", 2'd0, 1'b1, 1'b0);
      rst_n = 1'b1;
      blank_window("R9 release", TCL, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule